// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator

This block produces four independent pulse-width-modulated outputs. Each channel has three registers: a 16-bit period, a 16-bit duty and a control word. The control word holds a two-bit divider code and an output inversion bit. All channels run from a shared base tick enable, nominally 1 MHz, which each channel slows by 1, 2, 4 or 8 before it steps its period counter.

Software writes go to shadow copies only. A write to a channel's period register arms a commit. The armed settings become live at the end of the period that is running, or at the next base tick if the channel is idle. Every period therefore runs entirely with old settings or entirely with new ones. A zero period committed this way stops the channel once its last period ends, and the output then stays low. Reads return the shadow (programmed) values through a simple address/strobe interface.

Top module: `pwm_multi`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register reads zero, every channel is stopped and every output is low.
- R2: Channel n's period register decodes at address 0x400 + 4n, its duty register at 0x420 + 4n and its control register at 0x440 + 4n. A write to any other address changes no register and no output.
- R3: The period and duty registers read back the low 16 bits last written. The control register reads back the divider code in bits [1:0] and the inversion bit in bit 5. Every other bit reads zero.
- R4: With the inversion bit clear, a running channel's output is high for the first `duty` prescaled ticks of each period and low for the rest of it. A period lasts `period` prescaled ticks.
- R5: Divider codes 0, 1, 2 and 3 make a prescaled tick once every 1, 2, 4 and 8 base ticks.
- R6: With the inversion bit (control bit 5) set, a running channel's output is the complement of the R4 waveform.
- R7: With the inversion bit clear, a duty of 0 gives a constant low output and a duty equal to or above the period gives a constant high output. With the inversion bit set, these two cases give the opposite constant levels.
- R8: Writes to the duty and control registers never change the output until a period write follows them.
- R9: After a period write to a running channel, the period in progress completes with the old settings. The shadowed period, duty, divider and inversion all take effect together at the next period boundary.
- R10: A nonzero period write to an idle channel commits at the first base tick after the write. The output shows the first tick of the new period in the cycle after that tick.
- R11: A committed zero period lets the running period finish, then stops the channel. The output then stays low whatever the inversion bit says.
- R12: The prescaler restarts at every period boundary, so a divider change takes effect exactly at the start of the new period.
- R13: In a cycle where the base tick is low, no channel advances and no output changes.
- R14: Channels are independent. Programming one channel never changes another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| tick_i | input | 1 | Base tick enable shared by all channels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (11) | Byte address of the register to read or write |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| pwm_o | output | N_CH (4) | One PWM output per channel |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters, a two-bit divider code and the standard register bases. This puts every address decode and every divider code within reach. Periods of two to five prescaled ticks keep even a divide-by-8 waveform inside a few dozen cycles, so each of the vectors can check two whole periods cycle by cycle. Periods near the 16-bit maximum are covered only by the counter-range property, not by a full waveform.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int PWM_CNT_W = 16;
  localparam int PWM_DIV_W = 2;
  // prescale counter must reach 2**(2**DIV_W - 1) - 1
  localparam int PWM_PRE_W = (1 << PWM_DIV_W) - 1;

  typedef struct packed {
    logic                 inv;
    logic [PWM_DIV_W-1:0] div;
    logic [PWM_CNT_W-1:0] duty;
    logic [PWM_CNT_W-1:0] per;
  } pwm_cfg_t;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int N_CH       = 4,
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 32,
  parameter int PER_BASE   = 'h400,
  parameter int DUTY_BASE  = 'h420,
  parameter int CTL_BASE   = 'h440,
  parameter int REG_STRIDE = 4,
  parameter int INV_BIT    = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output pwm_cfg_t [N_CH-1:0]     shd_o,
  output logic [N_CH-1:0]         per_wr_o
);

  function automatic logic [ADDR_W-1:0] reg_addr(input int base, input int ch);
    return ADDR_W'(base + ch * REG_STRIDE);
  endfunction

  pwm_cfg_t [N_CH-1:0] shd_q, shd_n;
  logic     [N_CH-1:0] hit_per, hit_duty, hit_ctl;

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      hit_per[i]  = wr_en_i && (addr_i == reg_addr(PER_BASE, i));
      hit_duty[i] = wr_en_i && (addr_i == reg_addr(DUTY_BASE, i));
      hit_ctl[i]  = wr_en_i && (addr_i == reg_addr(CTL_BASE, i));
    end
  end

  always_comb begin
    shd_n = shd_q;
    for (int i = 0; i < N_CH; i++) begin
      if (hit_per[i])  shd_n[i].per  = wdata_i[PWM_CNT_W-1:0];
      if (hit_duty[i]) shd_n[i].duty = wdata_i[PWM_CNT_W-1:0];
      if (hit_ctl[i]) begin
        shd_n[i].div = wdata_i[PWM_DIV_W-1:0];
        shd_n[i].inv = wdata_i[INV_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shd_q <= '0;
    else        shd_q <= shd_n;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (addr_i == reg_addr(PER_BASE, i))  rdata_o = DATA_W'(shd_q[i].per);
      if (addr_i == reg_addr(DUTY_BASE, i)) rdata_o = DATA_W'(shd_q[i].duty);
      if (addr_i == reg_addr(CTL_BASE, i)) begin
        rdata_o[PWM_DIV_W-1:0] = shd_q[i].div;
        rdata_o[INV_BIT]       = shd_q[i].inv;
      end
    end
  end

  assign shd_o    = shd_q;
  assign per_wr_o = hit_per;

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 run_i,
  input  logic                 clear_i,
  input  logic [PWM_DIV_W-1:0] div_i,
  output logic                 ptick_o,
  output logic [PWM_PRE_W-1:0] pre_o
);

  logic [PWM_PRE_W-1:0] pre_q, pre_n, lim;

  always_comb begin
    lim     = {PWM_PRE_W{1'b1}} >> (PWM_PRE_W - int'(div_i));
    ptick_o = run_i && tick_i && (pre_q == lim);
    pre_n   = pre_q;
    if (clear_i)
      pre_n = '0;
    else if (run_i && tick_i)
      pre_n = ptick_o ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_n;
  end

  assign pre_o = pre_q;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 per_wr_i,
  input  pwm_cfg_t             shd_i,
  output logic                 pwm_o,
  output logic                 run_o,
  output logic [PWM_CNT_W-1:0] cnt_o,
  output pwm_cfg_t             live_o,
  output logic [PWM_PRE_W-1:0] pre_o
);

  pwm_cfg_t             cfg_q, cfg_n;
  logic [PWM_CNT_W-1:0] cnt_q, cnt_n;
  logic                 run_q, run_n;
  logic                 pend_q, pend_n;
  logic                 ptick, last, boundary, start, load;

  pwm_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .run_i   (run_q),
    .clear_i (load),
    .div_i   (cfg_q.div),
    .ptick_o (ptick),
    .pre_o   (pre_o)
  );

  always_comb begin
    last     = (cnt_q == cfg_q.per - 1'b1);
    boundary = ptick && last;
    start    = !run_q && tick_i && pend_q;
    load     = (boundary && pend_q) || start;

    cfg_n  = cfg_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    pend_n = pend_q;

    if (ptick)
      cnt_n = last ? '0 : cnt_q + 1'b1;
    if (load) begin
      cfg_n  = shd_i;
      run_n  = |shd_i.per;
      cnt_n  = '0;
      pend_n = 1'b0;
    end
    if (per_wr_i)
      pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      pend_q <= pend_n;
    end
  end

  assign pwm_o  = run_q && ((cnt_q < cfg_q.duty) ^ cfg_q.inv);
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;
  assign live_o = cfg_q;

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int N_CH       = 4,
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 32,
  parameter int PER_BASE   = 'h400,
  parameter int DUTY_BASE  = 'h420,
  parameter int CTL_BASE   = 'h440,
  parameter int REG_STRIDE = 4,
  parameter int INV_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   pwm_o
);

  pwm_cfg_t [N_CH-1:0]                 shd_v;
  pwm_cfg_t [N_CH-1:0]                 live_v;
  logic     [N_CH-1:0]                 per_wr_v;
  logic     [N_CH-1:0]                 run_v;
  logic     [N_CH-1:0][PWM_CNT_W-1:0]  cnt_v;
  logic     [N_CH-1:0][PWM_PRE_W-1:0]  pre_v;

  pwm_regfile #(
    .N_CH       (N_CH),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PER_BASE   (PER_BASE),
    .DUTY_BASE  (DUTY_BASE),
    .CTL_BASE   (CTL_BASE),
    .REG_STRIDE (REG_STRIDE),
    .INV_BIT    (INV_BIT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .shd_o    (shd_v),
    .per_wr_o (per_wr_v)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .per_wr_i (per_wr_v[g]),
      .shd_i    (shd_v[g]),
      .pwm_o    (pwm_o[g]),
      .run_o    (run_v[g]),
      .cnt_o    (cnt_v[g]),
      .live_o   (live_v[g]),
      .pre_o    (pre_v[g])
    );
  end

endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk
  import pwm_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick_i,
  input  logic [N_CH-1:0]                     pwm_o,
  input  logic [N_CH-1:0]                     run_v,
  input  logic [N_CH-1:0][PWM_CNT_W-1:0]      cnt_v,
  input  pwm_cfg_t [N_CH-1:0]                 live_v,
  input  logic [N_CH-1:0][PWM_PRE_W-1:0]      pre_v
);

  // R13
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pwm_o));

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_v[g] |-> (cnt_v[g] < live_v[g].per));

    // R9
    cfg_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[g] && (cnt_v[g] != live_v[g].per - 1'b1)) |=> $stable(live_v[g]));

    // R11
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_v[g] |-> !pwm_o[g]);

    // R5
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_v[g] |-> (32'(pre_v[g]) < (32'd1 << live_v[g].div)));
  end

endmodule

bind pwm_multi pwm_multi_chk #(.N_CH(N_CH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick_i (tick_i),
  .pwm_o  (pwm_o),
  .run_v  (run_v),
  .cnt_v  (cnt_v),
  .live_v (live_v),
  .pre_v  (pre_v)
);

// File: tb/pwm_multi_test.sv
module pwm_multi_test;

  localparam int CLK_PERIOD = 10;
  localparam int PER_A  = 'h400;
  localparam int DUTY_A = 'h420;
  localparam int CTL_A  = 'h440;

  // {ch[1:0], div[1:0], inv, duty[15:0], per[15:0]}
  localparam int NVEC = 8;
  localparam logic [36:0] VECS [NVEC] = '{
    {2'd0, 2'd0, 1'b0, 16'd2, 16'd5},
    {2'd1, 2'd1, 1'b0, 16'd1, 16'd3},
    {2'd2, 2'd2, 1'b1, 16'd1, 16'd4},
    {2'd3, 2'd3, 1'b0, 16'd3, 16'd2},
    {2'd1, 2'd0, 1'b0, 16'd0, 16'd4},
    {2'd2, 2'd0, 1'b1, 16'd0, 16'd3},
    {2'd3, 2'd1, 1'b1, 16'd5, 16'd5},
    {2'd0, 2'd3, 1'b1, 16'd2, 16'd3}
  };

  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        wr_en_i;
  logic [10:0] addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [3:0]  pwm_o;

  int total = 0;
  int bad   = 0;

  pwm_multi uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pwm_o   (pwm_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic exp_lvl(input int k, input int per, input int duty,
                                   input int dv, input int inv);
    int c;
    c = (k >> dv) % per;
    return ((c < duty) ? 1'b1 : 1'b0) ^ inv[0];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic put_wr(input int a, input int d);
    addr_i  = 11'(a);
    wdata_i = 32'(d);
    wr_en_i = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    put_wr(a, d);
    step();
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr_i = 11'(a);
    #1;
    d = rdata_o;
  endtask

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input int a, input int exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == 32'(exp), req, d, 32'(exp));
  endtask

  // n steps; phase k0.. of the waveform of channel ch, others must be low
  task automatic run_chk(input int n, input int k0, input int ch, input int per,
                         input int duty, input int dv, input int inv, input string req);
    int   errs;
    logic [3:0] fa, fe;
    errs = 0;
    fa = '0;
    fe = '0;
    for (int j = 0; j < n; j++) begin
      logic [3:0] e;
      step();
      e = '0;
      e[ch] = exp_lvl(k0 + j, per, duty, dv, inv);
      if (pwm_o !== e) begin
        if (errs == 0) begin
          fa = pwm_o;
          fe = e;
        end
        errs++;
      end
    end
    chk(errs == 0, req, 32'(fa), 32'(fe));
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    wr_en_i = 1'b0;
    tick_i  = 1'b1;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    tick_i  = 1'b1;
    wr_en_i = 1'b0;
    addr_i  = '0;
    wdata_i = '0;
    do_reset();

    // R1: reset state
    chk(pwm_o == 4'b0, "R1 outputs after reset", 32'(pwm_o), 32'h0);
    for (int c = 0; c < 4; c++) begin
      chk_rd(PER_A + 4 * c, 0, "R1 period reads zero");
      chk_rd(CTL_A + 4 * c, 0, "R1 control reads zero");
    end

    // vector table: R4 R5 R6 R7 R10 R14 R3 R2
    for (int v = 0; v < NVEC; v++) begin
      int ch, dv, inv, duty, per;
      ch   = int'(VECS[v][36:35]);
      dv   = int'(VECS[v][34:33]);
      inv  = int'(VECS[v][32]);
      duty = int'(VECS[v][31:16]);
      per  = int'(VECS[v][15:0]);
      do_reset();
      wr(CTL_A + 4 * ch, dv | (inv << 5));
      wr(DUTY_A + 4 * ch, duty);
      wr(PER_A + 4 * ch, per);
      chk_rd(CTL_A + 4 * ch, dv | (inv << 5), "R3 control readback");
      chk_rd(DUTY_A + 4 * ch, duty, "R3 duty readback R2");
      run_chk(2 * (per << dv), 0, ch, per, duty, dv, inv,
              "R4 R5 R6 R7 R10 R14 waveform vector");
    end

    // R2: writes outside the map; R3: reserved control bits
    do_reset();
    wr('h410, 'hFFFF);
    wr('h000, 'hFFFF);
    wr('h450, 'h23);
    wr('h43C, 'h7);
    for (int c = 0; c < 4; c++) begin
      chk_rd(PER_A + 4 * c, 0, "R2 period untouched");
      chk_rd(DUTY_A + 4 * c, 0, "R2 duty untouched");
      chk_rd(CTL_A + 4 * c, 0, "R2 control untouched");
    end
    wr(CTL_A, -1);
    chk_rd(CTL_A, 'h23, "R3 reserved control bits read zero");
    run_chk(4, 0, 0, 1, 0, 0, 0, "R8 control write alone keeps output low");

    // R8 R9: shadow duty, commit at boundary
    do_reset();
    wr(CTL_A, 0);
    wr(DUTY_A, 1);
    wr(PER_A, 4);
    run_chk(6, 0, 0, 4, 1, 0, 0, "R10 start from idle");
    put_wr(DUTY_A, 3);
    run_chk(4, 6, 0, 4, 1, 0, 0, "R8 shadow duty not applied");
    put_wr(PER_A, 4);
    run_chk(2, 10, 0, 4, 1, 0, 0, "R9 running period keeps old duty");
    run_chk(8, 0, 0, 4, 3, 0, 0, "R9 new duty from boundary");
    chk_rd(DUTY_A, 3, "R3 duty readback after commit");

    // R12: divider change aligned to boundary
    do_reset();
    wr(CTL_A + 4, 1);
    wr(DUTY_A + 4, 2);
    wr(PER_A + 4, 3);
    run_chk(3, 0, 1, 3, 2, 1, 0, "R5 divide by two");
    put_wr(CTL_A + 4, 0);
    run_chk(1, 3, 1, 3, 2, 1, 0, "R8 divider shadowed");
    put_wr(PER_A + 4, 3);
    run_chk(2, 4, 1, 3, 2, 1, 0, "R12 old divider to period end");
    run_chk(9, 0, 1, 3, 2, 0, 0, "R12 new divider from boundary");

    // R11: disable with inverted output, then restart
    do_reset();
    wr(CTL_A + 8, 'h20);
    wr(DUTY_A + 8, 1);
    wr(PER_A + 8, 4);
    run_chk(6, 0, 2, 4, 1, 0, 1, "R6 inverted running");
    put_wr(PER_A + 8, 0);
    run_chk(2, 6, 2, 4, 1, 0, 1, "R11 period finishes after zero write");
    run_chk(8, 0, 2, 1, 0, 0, 0, "R11 output low once stopped");
    chk_rd(PER_A + 8, 0, "R3 period reads zero");
    chk_rd(CTL_A + 8, 'h20, "R3 inversion bit kept");
    wr(PER_A + 8, 4);
    run_chk(4, 0, 2, 4, 1, 0, 1, "R10 restart after stop");

    // R13: base tick low holds everything
    do_reset();
    wr(DUTY_A + 12, 2);
    wr(PER_A + 12, 4);
    run_chk(2, 0, 3, 4, 2, 0, 0, "R4 before tick gap");
    tick_i = 1'b0;
    begin
      int errs;
      errs = 0;
      for (int j = 0; j < 5; j++) begin
        step();
        if (pwm_o !== 4'b1000) errs++;
      end
      chk(errs == 0, "R13 output held with tick low", 32'(pwm_o), 32'h8);
    end
    tick_i = 1'b1;
    run_chk(6, 2, 3, 4, 2, 0, 0, "R13 resumes after tick gap");

    // R1: asynchronous reset during a run
    rst_n = 1'b0;
    #1;
    chk(pwm_o == 4'b0, "R1 outputs low in reset", 32'(pwm_o), 32'h0);
    chk_rd(PER_A + 12, 0, "R1 period cleared by reset");
    step();
    rst_n = 1'b1;
    run_chk(3, 0, 3, 1, 0, 0, 0, "R1 stays stopped after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule